// File: doc/BRIEF.md
# Polarity-Selectable Event Flag Controller

This block keeps a bank of sticky flags that record events seen on a synchronous event bus, so that a consumer in another power or clock domain can pick them up later. Every hardware source has its own polarity bit. Comparator-style sources are edge sources: they set their flag on a rising or a falling transition. Timer, conversion-done and similar sources are level sources: they keep setting their flag while the input sits at the chosen level. Three further flags belong to software, which can raise them through a set-only register.

Software clears a flag in one of two ways. It can write one to the flag's bit in a clear register, or it can write zero to that bit in the flag register itself. Writing one to a bit of the flag register sets the flag. A mask register selects the flags that drive one combined output, which is meant to serve as a single wake or interrupt line. All registers sit on a plain word bus with address, write enable, write data and read data. Writes take effect at the clock edge. Read data is combinational from the addressed register.

Flag bit layout: bits 0..N_SW-1 are the software flags, the next N_EDGE bits are the edge sources, and the last N_LEVEL bits are the level sources. Register addresses are: 0 flags, 1 polarity, 2 clear, 3 software set, 4 mask.

Top module: `efc_event_flags`

## Requirements
- R1: While reset is low, the flags, polarity bits and mask bits are all zero and `comb_o` is low. The edge history follows the inputs during reset, so a level already present at release is not treated as an edge.
- R2: An edge source with polarity 1 sets its flag on a rising transition, and with polarity 0 on a falling transition. The transition is judged against the input seen at the previous clock. The flag reads 1 after the clock edge that saw the transition. A transition of the other direction leaves the flag alone.
- R3: A level source sets its flag on every clock at which its input equals its polarity bit: low for polarity 0, high for polarity 1.
- R4: Writing address 3 sets each software flag whose bit in write data [N_SW-1:0] is 1. Zero bits, and all bits above N_SW-1, have no effect. Address 3 reads 0.
- R5: Writing address 2 clears every flag whose write data bit is 1. Address 2 reads 0.
- R6: Writing address 0 clears each flag whose write data bit is 0 and sets each flag whose bit is 1. No flag rises without a hardware set or a software set.
- R7: A level flag whose source is still at the selected level stays set through any clear.
- R8: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.
- R9: `comb_o` is high exactly when at least one flag is set whose mask bit (address 4, bit i for flag i) is 1.
- R10: Polarity bits exist only at flag positions N_SW and above. Other polarity positions, and bits above the flag count in every register, read 0 and ignore writes. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the event bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register |
| src_edge_i | input | N_EDGE | Edge-type event sources |
| src_level_i | input | N_LEVEL | Level-type event sources |
| flags_o | output | N_SW+N_EDGE+N_LEVEL | Current sticky flags |
| comb_o | output | 1 | OR of the flags that are set and masked in |

## Verification
On every cycle the assertions check the following: a hardware set always lands despite a clear, a one-to-clear write empties the targeted flags when nothing sets them, no flag rises without a cause, a reported edge matches a real change of the input, and polarity, mask and software-set writes take hold one clock later. Only the bench scenarios can show the remaining behaviour, because it depends on the direction and timing of the stimulus: the rising versus falling choice, level flags that refuse to clear while their source is active, reserved bits that read zero, and the combined output following mask changes. A behavioural reference model is compared against the flags, the combined output and the read data at every clock, through directed phases and a random sweep.

// File: rtl/efc_pkg.sv
package efc_pkg;

    // Word addresses of the register bus
    typedef enum logic [2:0] {
        REG_FLAGS = 3'd0,
        REG_POL   = 3'd1,
        REG_CLR   = 3'd2,
        REG_SET   = 3'd3,
        REG_MASK  = 3'd4
    } efc_reg_e;

endpackage

// File: rtl/efc_trigger.sv
module efc_trigger #(
    parameter int N_EDGE  = 2,
    parameter int N_LEVEL = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_EDGE-1:0]          edge_in,
    input  logic [N_LEVEL-1:0]         level_in,
    input  logic [N_EDGE+N_LEVEL-1:0]  pol,
    output logic [N_EDGE+N_LEVEL-1:0]  hw_set
);
    localparam int N_HW = N_EDGE + N_LEVEL;

    typedef struct packed {
        logic [N_EDGE-1:0] prev;
    } trig_state_t;

    trig_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = edge_in;
    end

    // History is sampled in reset too, so release never fakes an edge
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        assign hw_set[g] = pol[g] ? (edge_in[g] & ~st_q.prev[g])
                                  : (~edge_in[g] & st_q.prev[g]);
    end

    for (genvar g = 0; g < N_LEVEL; g++) begin : g_level
        assign hw_set[N_EDGE+g] = ~(level_in[g] ^ pol[N_EDGE+g]);
    end

    // An edge hit must coincide with a change of that input since last clock
    p_edge_needs_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set[N_EDGE-1:0]) |->
            ((hw_set[N_EDGE-1:0] & ~(edge_in ^ $past(edge_in))) == '0));

    localparam int UNUSED_HW = N_HW;
endmodule

// File: rtl/efc_ctrl_regs.sv
module efc_ctrl_regs #(
    parameter int N_SW   = 3,
    parameter int N_FLAG = 9,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [N_FLAG-1:0]    flags,
    output logic [N_FLAG-1:N_SW] pol_q,
    output logic [N_FLAG-1:0]    mask_q,
    output logic [N_FLAG-1:0]    sw_set,
    output logic [N_FLAG-1:0]    sw_clr,
    output logic [DATA_W-1:0]    reg_rdata
);
    import efc_pkg::*;

    typedef struct packed {
        logic [N_FLAG-1:N_SW] pol;
        logic [N_FLAG-1:0]    mask;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [N_FLAG-1:0] wlow;
    logic sel_flags, sel_pol, sel_clr, sel_set, sel_mask;

    always_comb begin
        wlow      = N_FLAG'(reg_wdata);
        sel_flags = reg_addr == ADDR_W'(REG_FLAGS);
        sel_pol   = reg_addr == ADDR_W'(REG_POL);
        sel_clr   = reg_addr == ADDR_W'(REG_CLR);
        sel_set   = reg_addr == ADDR_W'(REG_SET);
        sel_mask  = reg_addr == ADDR_W'(REG_MASK);

        st_d = st_q;
        if (reg_we && sel_pol)  st_d.pol  = wlow[N_FLAG-1:N_SW];
        if (reg_we && sel_mask) st_d.mask = wlow;

        sw_set = '0;
        sw_clr = '0;
        if (reg_we && sel_flags) begin
            sw_set = wlow;
            sw_clr = ~wlow;
        end
        if (reg_we && sel_clr) sw_clr = wlow;
        if (reg_we && sel_set) sw_set[N_SW-1:0] = wlow[N_SW-1:0];

        reg_rdata = '0;
        if (sel_flags) reg_rdata = DATA_W'(flags);
        if (sel_pol)   reg_rdata = DATA_W'({st_q.pol, {N_SW{1'b0}}});
        if (sel_mask)  reg_rdata = DATA_W'(st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pol_q  = st_q.pol;
    assign mask_q = st_q.mask;

    p_pol_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel_pol) |=> (pol_q == $past(reg_wdata[N_FLAG-1:N_SW])));

    p_mask_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel_mask) |=> (mask_q == $past(reg_wdata[N_FLAG-1:0])));
endmodule

// File: rtl/efc_flag_bank.sv
module efc_flag_bank #(
    parameter int N_FLAG = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] hw_set,
    input  logic [N_FLAG-1:0] sw_set,
    input  logic [N_FLAG-1:0] sw_clr,
    input  logic [N_FLAG-1:0] mask,
    output logic [N_FLAG-1:0] flags_q,
    output logic              comb_o
);
    typedef struct packed {
        logic [N_FLAG-1:0] flags;
    } bank_state_t;

    bank_state_t st_d, st_q;

    // Any set beats a clear on the same flag
    always_comb begin
        st_d       = st_q;
        st_d.flags = hw_set | sw_set | (st_q.flags & ~sw_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;
    assign comb_o  = |(st_q.flags & mask);

    p_hw_set_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((flags_q & $past(hw_set)) == $past(hw_set)));

    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_clr & ~hw_set & ~sw_set)) |=>
            ((flags_q & $past(sw_clr & ~hw_set & ~sw_set)) == '0));

    p_no_spurious_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(hw_set | sw_set)) == '0));
endmodule

// File: rtl/efc_event_flags.sv
module efc_event_flags #(
    parameter int N_SW    = 3,
    parameter int N_EDGE  = 2,
    parameter int N_LEVEL = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic                              reg_we,
    input  logic [DATA_W-1:0]                 reg_wdata,
    output logic [DATA_W-1:0]                 reg_rdata,
    input  logic [N_EDGE-1:0]                 src_edge_i,
    input  logic [N_LEVEL-1:0]                src_level_i,
    output logic [N_SW+N_EDGE+N_LEVEL-1:0]    flags_o,
    output logic                              comb_o
);
    import efc_pkg::*;

    localparam int N_HW   = N_EDGE + N_LEVEL;
    localparam int N_FLAG = N_SW + N_HW;

    logic [N_FLAG-1:N_SW] pol;
    logic [N_FLAG-1:0]    mask;
    logic [N_FLAG-1:0]    sw_set, sw_clr;
    logic [N_HW-1:0]      hw_src_set;
    logic [N_FLAG-1:0]    hw_set;

    efc_trigger #(.N_EDGE(N_EDGE), .N_LEVEL(N_LEVEL)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_in  (src_edge_i),
        .level_in (src_level_i),
        .pol      (pol),
        .hw_set   (hw_src_set)
    );

    assign hw_set = {hw_src_set, {N_SW{1'b0}}};

    efc_ctrl_regs #(.N_SW(N_SW), .N_FLAG(N_FLAG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .flags     (flags_o),
        .pol_q     (pol),
        .mask_q    (mask),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr),
        .reg_rdata (reg_rdata)
    );

    efc_flag_bank #(.N_FLAG(N_FLAG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_set  (hw_set),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .mask    (mask),
        .flags_q (flags_o),
        .comb_o  (comb_o)
    );

    p_swset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(REG_SET)) |=>
            ((flags_o[N_SW-1:0] & $past(reg_wdata[N_SW-1:0])) == $past(reg_wdata[N_SW-1:0])));
endmodule

// File: tb/sim_efc_event_flags.sv
`timescale 1ns/1ps
module sim_efc_event_flags;
    localparam int NS = 3, NE = 2, NL = 4, NF = NS + NE + NL, DW = 32, AW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NE-1:0] src_edge = '0;
    logic [NL-1:0] src_level = '1;
    logic [NF-1:0] flags_o;
    logic          comb_o;

    efc_event_flags #(.N_SW(NS), .N_EDGE(NE), .N_LEVEL(NL), .DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_edge_i(src_edge),
        .src_level_i(src_level), .flags_o(flags_o), .comb_o(comb_o)
    );

    // Reference model state
    bit [NF-1:0] m_flags, m_pol, m_mask;
    bit [NE-1:0] m_prev;
    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;
    string tag = "R1";

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit [NF-1:0] hs, ss, cc;
        if (!rst_n) begin
            m_flags = '0; m_pol = '0; m_mask = '0; m_prev = src_edge;
            return;
        end
        hs = '0; ss = '0; cc = '0;
        for (int i = 0; i < NE; i++) begin
            if (m_pol[NS+i]) hs[NS+i] = src_edge[i] && !m_prev[i];
            else             hs[NS+i] = !src_edge[i] && m_prev[i];
        end
        for (int i = 0; i < NL; i++)
            hs[NS+NE+i] = (src_level[i] == m_pol[NS+NE+i]);
        if (reg_we) begin
            case (int'(reg_addr))
                0: begin ss = reg_wdata[NF-1:0]; cc = ~reg_wdata[NF-1:0]; end
                2: cc = reg_wdata[NF-1:0];
                3: for (int i = 0; i < NS; i++) ss[i] = reg_wdata[i];
                default: ;
            endcase
        end
        for (int i = 0; i < NF; i++) begin
            if (hs[i] || ss[i]) m_flags[i] = 1'b1;
            else if (cc[i])     m_flags[i] = 1'b0;
        end
        if (reg_we && reg_addr == 3'd1)
            for (int i = 0; i < NF; i++) m_pol[i] = (i >= NS) ? reg_wdata[i] : 1'b0;
        if (reg_we && reg_addr == 3'd4) m_mask = reg_wdata[NF-1:0];
        m_prev = src_edge;
    endtask

    function automatic logic [31:0] exp_rd();
        case (int'(reg_addr))
            0: return 32'(m_flags);
            1: return 32'(m_pol);
            4: return 32'(m_mask);
            default: return 32'h0;
        endcase
    endfunction

    task automatic cyc();
        model_step();
        @(posedge clk);
        #1;
        chk(tag, 32'(flags_o), 32'(m_flags), "flags");
        chk(tag, 32'(comb_o), 32'(|(m_flags & m_mask)), "comb");
        chk(tag, reg_rdata, exp_rd(), "rdata");
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [AW-1:0] a);
        reg_we = 1'b0; reg_addr = a;
        cyc();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) cyc();
        chk("R1", 32'(flags_o), 0, "flags in reset");
        chk("R1", 32'(comb_o), 0, "comb in reset");
        rst_n = 1'b1;
        repeat (2) cyc();
        chk("R1", 32'(flags_o), 0, "flags after release");
        rd(3'd1); chk("R1", reg_rdata, 0, "pol reset");
        rd(3'd4); chk("R1", reg_rdata, 0, "mask reset");

        // R2: edge sources
        tag = "R2";
        wr(3'd1, 32'h008);
        src_edge[0] = 1'b1; cyc();
        chk("R2", 32'(flags_o[3]), 1, "rising sets pol1");
        src_edge[1] = 1'b1; cyc();
        chk("R2", 32'(flags_o[4]), 0, "rising ignored on pol0");
        src_edge[1] = 1'b0; cyc();
        chk("R2", 32'(flags_o[4]), 1, "falling sets pol0");
        src_edge[0] = 1'b0; cyc();

        // R5: write-one-to-clear
        tag = "R5";
        wr(3'd2, 32'h018);
        chk("R5", 32'(flags_o), 0, "w1c result");
        rd(3'd2); chk("R5", reg_rdata, 0, "clear reads 0");

        // R4: software set
        tag = "R4";
        wr(3'd3, 32'h5);
        chk("R4", 32'(flags_o), 32'h005, "sw set");
        wr(3'd3, 32'h0);
        chk("R4", 32'(flags_o), 32'h005, "zero write no effect");
        wr(3'd3, 32'hFFFF_FFF8);
        chk("R4", 32'(flags_o), 32'h005, "upper bits ignored");
        rd(3'd3); chk("R4", reg_rdata, 0, "set reads 0");

        // R6: direct flag register writes
        tag = "R6";
        wr(3'd0, 32'h006);
        chk("R6", 32'(flags_o), 32'h006, "zero clears one sets");
        wr(3'd0, 32'h010);
        chk("R6", 32'(flags_o), 32'h010, "overwrite");
        wr(3'd0, 32'h0);

        // R3 / R7: level sources
        tag = "R3";
        src_level[0] = 1'b0; cyc();
        chk("R3", 32'(flags_o[5]), 1, "low level pol0 sets");
        tag = "R7";
        wr(3'd2, 32'h020);
        chk("R7", 32'(flags_o[5]), 1, "clear blocked while active");
        wr(3'd0, 32'h0);
        chk("R7", 32'(flags_o[5]), 1, "zero write blocked while active");
        src_level[0] = 1'b1; cyc();
        chk("R7", 32'(flags_o[5]), 1, "sticky after release");
        wr(3'd2, 32'h020);
        chk("R7", 32'(flags_o[5]), 0, "clears once inactive");
        tag = "R3";
        wr(3'd1, 32'h048);
        cyc();
        chk("R3", 32'(flags_o[6]), 1, "high level pol1 sets");
        src_level[1] = 1'b0;
        wr(3'd2, 32'h040);
        chk("R3", 32'(flags_o[6]), 0, "cleared after drop");

        // R8: set beats clear
        tag = "R8";
        src_edge[0] = 1'b1;
        wr(3'd2, 32'h008);
        chk("R8", 32'(flags_o[3]), 1, "edge set wins over clear");
        src_edge[0] = 1'b0;
        wr(3'd2, 32'h008);

        // R9: combined output
        tag = "R9";
        wr(3'd3, 32'h2);
        wr(3'd4, 32'h001);
        chk("R9", 32'(comb_o), 0, "unmasked flag excluded");
        wr(3'd4, 32'h002);
        chk("R9", 32'(comb_o), 1, "masked flag included");
        wr(3'd2, 32'h002);
        chk("R9", 32'(comb_o), 0, "drops with flag");

        // R10: reserved bits
        tag = "R10";
        src_level = 4'h0;
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1); chk("R10", reg_rdata, 32'h1F8, "pol reserved");
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4); chk("R10", reg_rdata, 32'h1FF, "mask reserved");
        rd(3'd5); chk("R10", reg_rdata, 0, "addr 5");
        rd(3'd7); chk("R10", reg_rdata, 0, "addr 7");
        wr(3'd0, 32'hFFFF_FE00);
        rd(3'd0); chk("R10", reg_rdata, 0, "flag upper bits");

        // Random sweep over all rules (R2 R3 R8 sweep)
        tag = "R2_R3_R8_sweep";
        for (int k = 0; k < 600; k++) begin
            src_edge  = NE'($urandom);
            src_level = NL'($urandom);
            reg_we    = ($urandom % 3) == 0;
            reg_addr  = AW'($urandom);
            reg_wdata = $urandom;
            cyc();
        end
        reg_we = 1'b0;
        cyc();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule